// File: doc/BRIEF.md
# I2C Write-Only Bus Master

This block drives write transactions onto a two-wire open-drain bus. A host hands it a request carrying a target address and a flag that picks a 7-bit or a 10-bit address phase. It then pulls payload bytes one at a time from a valid/ready stream and shifts each one onto the data line, most significant bit first. The stream marks the final byte, so a transfer may carry any number of bytes. Every byte the block sends is followed by an acknowledge slot. In that slot the block releases the data line and reads back what the target does with it.

The block marks the start of a transfer by pulling the data line low while the clock line is released. It marks the end by releasing the data line while the clock line is released. If the target leaves an acknowledge slot high, the block sends nothing more and closes the bus straight away. Two 7-bit address patterns are reserved for other purposes, and a request that uses one of them is refused without any bus activity. The clock period is four times a divider count of system clocks. Both lines are modelled as output enables: a 1 pulls the line low and a 0 releases it.

Top module: `i2c_wr_master`

## Requirements
- R1: After reset both enables are 0 (lines released), `req_ready` is 1 and `done` is 0.
- R2: Each transfer has exactly one start event (SDA falls while SCL is high) and one stop event (SDA rises while SCL is high). Outside those two events, SDA changes only while SCL is low.
- R3: In 7-bit mode the first byte on the bus is `{req_addr[6:0], 1'b0}`, sent MSB first. The trailing 0 is the write direction bit.
- R4: In 10-bit mode the first byte is `{5'b11110, req_addr[9:8], 1'b0}` and the second byte is `req_addr[7:0]`. Each of the two bytes has its own acknowledge slot.
- R5: Payload bytes appear on the bus in stream order, with no limit on their number. After the acknowledge of the byte that carried `byte_last`, the block issues stop.
- R6: During the ninth clock of every byte SDA is released. A low level sampled there counts as an acknowledge.
- R7: A high level in any acknowledge slot, whether on an address byte or a data byte, ends the transfer. No further byte is taken or sent, stop follows, and `done` rises with `err_nack` = 1.
- R8: A 7-bit request whose address bits [6:2] are 5'b00001 or 5'b11111 is refused. `done` and `err_addr` go high on the second clock edge after acceptance, and both lines stay released.
- R9: While a byte is being shifted, the SCL period is 4 × `div_cnt` system clocks. A value of 0 acts as 1.
- R10: While the block waits for the next payload byte (`byte_ready` = 1), SCL is held low.
- R11: `done` is high for exactly one cycle per request. `err_nack` and `err_addr` are high only in that cycle. `req_ready` is 0 from acceptance until the cycle `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_cnt | input | DIV_W | System clocks per quarter of an SCL period |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_addr | input | 10 | Target address; bits [6:0] used in 7-bit mode |
| req_ten | input | 1 | 1 selects the 10-bit address phase |
| byte_valid | input | 1 | Payload byte present |
| byte_ready | output | 1 | Block waiting for the next payload byte |
| byte_data | input | 8 | Payload byte |
| byte_last | input | 1 | Marks the final payload byte |
| sda_in | input | 1 | Sensed level of the data line |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| done | output | 1 | One-cycle end-of-request pulse |
| err_nack | output | 1 | With `done`: transfer aborted on a missing acknowledge |
| err_addr | output | 1 | With `done`: reserved 7-bit address refused |

## Verification
Almost any corruption of the bit counter, quarter counter or shift register shows up at the ports within one SCL period. It produces a wrong byte as the target sees it, an acknowledge slot at the wrong bit, or an extra start or stop event, because SDA then moves while SCL is high. A wrong byte-kind or last flag shows only at the end of a byte's acknowledge slot: the block sends one byte too many, fetches when it should stop, or skips the second address byte. A stuck abort path leaves `done` either missing or carrying the wrong error flag, and that is visible within three quarter periods of the bad acknowledge.

// File: rtl/i2c_wr_pkg.sv
package i2c_wr_pkg;
  localparam int ADDR_W = 10;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_START, ST_SEND, ST_FETCH, ST_STOP
  } wr_state_t;

  typedef enum logic [1:0] {
    BK_HDR1, BK_HDR2, BK_DATA
  } byte_kind_t;
endpackage

// File: rtl/i2c_quarter_tick.sv
module i2c_quarter_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div_cnt,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  assign lim  = (div_cnt == '0) ? DIV_W'(1) : div_cnt;
  assign tick = run && (cnt == lim - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + DIV_W'(1);
  end

  // R9: two back-to-back ticks only when a quarter is one clock long
  a_r9_quarter_len: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && $past(tick) && lim > DIV_W'(1)) |-> !tick);
endmodule

// File: rtl/i2c_wr_hdr.sv
module i2c_wr_hdr
  import i2c_wr_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              ten,
  output logic [BYTE_W-1:0] hdr1,
  output logic [BYTE_W-1:0] hdr2,
  output logic              bad
);
  logic [4:0] top5;
  assign top5 = addr[6:2];
  assign hdr1 = ten ? {5'b11110, addr[9:8], 1'b0} : {addr[6:0], 1'b0};
  assign hdr2 = addr[7:0];
  assign bad  = !ten && ((top5 == 5'b00001) || (top5 == 5'b11111));
endmodule

// File: rtl/i2c_wr_master.sv
module i2c_wr_master
  import i2c_wr_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_cnt,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [9:0]       req_addr,
  input  logic             req_ten,
  input  logic             byte_valid,
  output logic             byte_ready,
  input  logic [7:0]       byte_data,
  input  logic             byte_last,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             done,
  output logic             err_nack,
  output logic             err_addr
);
  localparam int BIT_W   = $clog2(BYTE_W + 1);
  localparam logic [BIT_W-1:0] ACK_SLOT = BIT_W'(BYTE_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  wr_state_t         state;
  byte_kind_t        kind;
  logic [1:0]        q;
  logic [BIT_W-1:0]  bit_idx;
  logic [BYTE_W-1:0] sh;
  logic [ADDR_W-1:0] addr_q;
  logic              ten_q, last_q, nack_q, ack_hi;
  logic              tick, run;
  logic [BYTE_W-1:0] hdr1, hdr2;
  logic              hdr_bad;

  assign req_ready  = (state == ST_IDLE);
  assign byte_ready = (state == ST_FETCH);
  assign run = (state == ST_START) || (state == ST_SEND) || (state == ST_STOP);

  i2c_quarter_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .run(run), .div_cnt(div_cnt), .tick(tick));

  i2c_wr_hdr u_hdr (
    .addr(addr_q), .ten(ten_q), .hdr1(hdr1), .hdr2(hdr2), .bad(hdr_bad));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;  kind <= BK_HDR1;  q <= '0;  bit_idx <= '0;
      sh <= '0;  addr_q <= '0;  ten_q <= 1'b0;  last_q <= 1'b0;
      nack_q <= 1'b0;  ack_hi <= 1'b0;  scl_oe <= 1'b0;  sda_oe <= 1'b0;
      done <= 1'b0;  err_nack <= 1'b0;  err_addr <= 1'b0;
    end else begin
      done <= 1'b0;  err_nack <= 1'b0;  err_addr <= 1'b0;
      unique case (state)
        ST_IDLE: if (req_valid) begin
          addr_q <= req_addr;  ten_q <= req_ten;  nack_q <= 1'b0;
          state  <= ST_CHECK;
        end
        ST_CHECK: if (hdr_bad) begin
          done <= 1'b1;  err_addr <= 1'b1;  state <= ST_IDLE;
        end else begin
          q <= '0;  state <= ST_START;
        end
        ST_START: if (tick) begin
          case (q)
            2'd0: begin sda_oe <= 1'b1; q <= 2'd1; end
            2'd1: begin scl_oe <= 1'b1; q <= 2'd2; end
            default: begin
              sh <= hdr1;  sda_oe <= ~hdr1[BYTE_W-1];  kind <= BK_HDR1;
              bit_idx <= '0;  q <= '0;  state <= ST_SEND;
            end
          endcase
        end
        ST_SEND: if (tick) begin
          case (q)
            2'd0: begin scl_oe <= 1'b0; q <= 2'd1; end
            2'd1: begin
              if (bit_idx == ACK_SLOT) ack_hi <= sda_in;
              q <= 2'd2;
            end
            2'd2: begin scl_oe <= 1'b1; q <= 2'd3; end
            default: begin
              q <= '0;
              if (bit_idx != ACK_SLOT) begin
                bit_idx <= bit_idx + BIT_W'(1);
                sh      <= {sh[BYTE_W-2:0], 1'b0};
                sda_oe  <= (bit_idx == LAST_BIT) ? 1'b0 : ~sh[BYTE_W-2];
              end else if (ack_hi) begin
                nack_q <= 1'b1;  sda_oe <= 1'b1;  state <= ST_STOP;
              end else if (kind == BK_HDR1 && ten_q) begin
                sh <= hdr2;  sda_oe <= ~hdr2[BYTE_W-1];  kind <= BK_HDR2;
                bit_idx <= '0;
              end else if (kind == BK_DATA && last_q) begin
                sda_oe <= 1'b1;  state <= ST_STOP;
              end else begin
                state <= ST_FETCH;
              end
            end
          endcase
        end
        ST_FETCH: if (byte_valid) begin
          sh <= byte_data;  sda_oe <= ~byte_data[BYTE_W-1];  last_q <= byte_last;
          kind <= BK_DATA;  bit_idx <= '0;  q <= '0;  state <= ST_SEND;
        end
        ST_STOP: if (tick) begin
          case (q)
            2'd0: begin scl_oe <= 1'b0; q <= 2'd1; end
            2'd1: begin sda_oe <= 1'b0; q <= 2'd2; end
            default: begin
              done <= 1'b1;  err_nack <= nack_q;  state <= ST_IDLE;
            end
          endcase
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1 / R11: an idle block leaves both lines released
  a_r1_idle_released: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!scl_oe && !sda_oe));
  // R11: single-cycle completion pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R11: error flags only accompany done
  a_r11_err_with_done: assert property (@(posedge clk) disable iff (rst)
    (err_nack || err_addr) |-> done);
  // R2: SDA frozen while SCL stays released inside a byte
  a_r2_sda_steady_high: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SEND && $past(state == ST_SEND) && !scl_oe && $past(!scl_oe))
      |-> $stable(sda_oe));
  // R10: SCL held low while waiting for payload
  a_r10_hold_low: assert property (@(posedge clk) disable iff (rst)
    byte_ready |-> scl_oe);
  // R8: a refused address never touches the bus
  a_r8_no_bus: assert property (@(posedge clk) disable iff (rst)
    err_addr |-> (!scl_oe && !sda_oe));
endmodule

// File: tb/i2c_wr_master_bench.sv
module i2c_wr_master_bench;
  localparam int DIV_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DIV_W-1:0] div_cnt = 8'd1;
  logic req_valid = 1'b0, req_ten = 1'b0;
  logic [9:0] req_addr = '0;
  logic byte_valid = 1'b0, byte_last = 1'b0;
  logic [7:0] byte_data = '0;
  logic req_ready, byte_ready, scl_oe, sda_oe, done, err_nack, err_addr;
  logic pull = 1'b0;
  logic sda_in;

  assign sda_in = ~sda_oe & ~pull;

  always #5 clk = ~clk;

  i2c_wr_master #(.DIV_W(DIV_W)) u_i2c_wr_master (
    .clk(clk), .rst(rst), .div_cnt(div_cnt),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_ten(req_ten),
    .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data),
    .byte_last(byte_last), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .done(done), .err_nack(err_nack), .err_addr(err_addr));

  int n_run = 0, n_fail = 0;
  int cyc = 0;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
    end
  end

  // target model and bus monitor, sampled on the falling clock edge
  int n_start = 0, n_stop = 0, rxn = 0, bitcnt = 0, last_rise = 0, period = 0;
  int wait_hi = 0;
  int cur_nack = -1;
  logic [7:0] mon_sh = '0;
  logic [7:0] rx [0:15];
  logic p_scl = 1'b1, p_sda = 1'b1;

  always @(negedge clk) begin
    logic scl_l, sda_l;
    scl_l = ~scl_oe;
    sda_l = ~sda_oe & ~pull;
    if (byte_ready && scl_l) wait_hi++;
    if (scl_l && p_scl && p_sda && !sda_l) begin n_start++; bitcnt = 0; end
    if (scl_l && p_scl && !p_sda && sda_l) n_stop++;
    if (!p_scl && scl_l) begin
      if (bitcnt < 8) begin
        if (bitcnt >= 1) period = cyc - last_rise;
        mon_sh = {mon_sh[6:0], sda_l};
        bitcnt++;
      end
      last_rise = cyc;
    end
    if (p_scl && !scl_l) begin
      if (bitcnt == 8) begin
        pull = (cur_nack != rxn);
        bitcnt = 9;
      end else if (bitcnt == 9) begin
        pull = 1'b0;
        if (rxn < 16) rx[rxn] = mon_sh;
        rxn++;
        bitcnt = 0;
      end
    end
    p_scl = scl_l;
    p_sda = ~sda_oe & ~pull;
  end

  typedef struct packed {
    logic [9:0] addr;
    logic       ten;
    logic [3:0] nb;
    logic [3:0] nack_at;  // 15 = target acknowledges everything
    logic [3:0] div;
    logic [3:0] gap;
  } vec_t;

  localparam vec_t VECS [0:6] = '{
    '{10'h050, 1'b0, 4'd3, 4'hF, 4'd2, 4'd0},
    '{10'h2A5, 1'b1, 4'd2, 4'hF, 4'd1, 4'd0},
    '{10'h013, 1'b0, 4'd4, 4'd0, 4'd1, 4'd0},
    '{10'h3C1, 1'b1, 4'd3, 4'd1, 4'd2, 4'd0},
    '{10'h077, 1'b0, 4'd5, 4'd3, 4'd1, 4'd3},
    '{10'h008, 1'b0, 4'd1, 4'hF, 4'd3, 4'd5},
    '{10'h07C, 1'b1, 4'd1, 4'hF, 4'd1, 4'd2}
  };

  function automatic logic [7:0] pay(input logic [9:0] a, input int k);
    return a[7:0] ^ (8'(k) * 8'd37 + 8'd5);
  endfunction

  function automatic logic [7:0] exp_byte(input vec_t v, input int i);
    int h;
    h = v.ten ? 2 : 1;
    if (i == 0) return v.ten ? {5'b11110, v.addr[9:8], 1'b0} : {v.addr[6:0], 1'b0};
    if (i < h) return v.addr[7:0];
    return pay(v.addr, i - h);
  endfunction

  logic over = 1'b0;
  int got_nack = 0, got_done = 0;

  task automatic do_req(input logic [9:0] a, input logic ten);
    @(negedge clk);
    req_addr = a; req_ten = ten; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R11 busy after accept", int'(req_ready), 0);
  endtask

  task automatic feed(input vec_t v);
    for (int k = 0; k < int'(v.nb); k++) begin
      repeat (int'(v.gap)) @(negedge clk);
      if (over) break;
      byte_data = pay(v.addr, k);
      byte_last = (k == int'(v.nb) - 1);
      byte_valid = 1'b1;
      forever begin
        if (byte_ready) begin @(posedge clk); @(negedge clk); break; end
        if (over) break;
        @(negedge clk);
      end
      byte_valid = 1'b0;
      if (over) break;
    end
  endtask

  task automatic wait_done();
    int t;
    t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    got_done = done;
    got_nack = err_nack;
    over = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R1 lines released", {scl_oe, sda_oe}, 0);
    chk(req_ready == 1'b1 && done == 1'b0, "R1 idle ready", {req_ready, done}, 2);

    for (int i = 0; i < 7; i++) begin
      vec_t v;
      int h, exp_n;
      logic ok_bytes;
      v = VECS[i];
      h = v.ten ? 2 : 1;
      exp_n = (v.nack_at != 4'hF) ? int'(v.nack_at) + 1 : h + int'(v.nb);
      cur_nack = (v.nack_at != 4'hF) ? int'(v.nack_at) : -1;
      div_cnt = 8'(v.div);
      n_start = 0; n_stop = 0; rxn = 0; period = 0; wait_hi = 0; over = 1'b0;
      fork
        do_req(v.addr, v.ten);
        feed(v);
        wait_done();
      join
      chk(got_done == 1, "R11 done seen", got_done, 1);
      @(negedge clk);
      chk(done == 1'b0 && err_nack == 1'b0, "R11 done one cycle", {done, err_nack}, 0);
      chk(rxn == exp_n, (v.nack_at != 4'hF) ? "R7 bytes before abort" : "R5 byte count", rxn, exp_n);
      ok_bytes = 1'b1;
      for (int b = 0; b < exp_n && b < 16; b++) if (rx[b] !== exp_byte(v, b)) ok_bytes = 1'b0;
      chk(ok_bytes, v.ten ? "R4 R6 ten-bit header and payload" : "R3 R6 seven-bit header and payload",
          int'(rx[0]), int'(exp_byte(v, 0)));
      chk(got_nack == int'(v.nack_at != 4'hF), "R7 err_nack", got_nack, int'(v.nack_at != 4'hF));
      chk(n_start == 1 && n_stop == 1, "R2 one start one stop", n_start * 10 + n_stop, 11);
      chk(period == 4 * int'(v.div), "R9 SCL period", period, 4 * int'(v.div));
      chk(wait_hi == 0, "R10 SCL low while waiting", wait_hi, 0);
      repeat (4) @(negedge clk);
    end

    // R8: reserved 7-bit patterns are refused
    for (int j = 0; j < 2; j++) begin
      logic [9:0] a;
      a = (j == 0) ? 10'h005 : 10'h07E;
      n_start = 0;
      do_req(a, 1'b0);
      chk(done == 1'b0, "R8 no done one edge after accept", int'(done), 0);
      @(negedge clk);
      chk(done && err_addr && !err_nack, "R8 err_addr at second edge", {done, err_addr, err_nack}, 6);
      chk(!scl_oe && !sda_oe && n_start == 0, "R8 bus untouched", n_start, 0);
      @(negedge clk);
      chk(!done && !err_addr, "R11 err_addr one cycle", {done, err_addr}, 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule